// File: doc/BRIEF.md
# I/O Instruction Condition-Code Controller

This block sits between the processor's I/O instruction path and a channel. The processor raises a one-cycle select strobe with a 2-bit operation and an 8-bit unit address that carries an odd parity bit. The four operations are start, test, halt and test-channel. The block checks the addressed subchannel state and decides what to do. Where needed, it runs memory reads and writes and device requests. It ends every instruction with a one-cycle release pulse that carries a 2-bit condition code.

A start reads the channel address word and then the first command word. It hands the command code to the device-side tag sequencer, which is a separate block reached through a request/done interface. It keeps the protection key and the command address plus 8 for chaining. The block also holds one pending end interrupt: a unit address and a 16-bit status word, posted from outside. Test and halt look this entry up. Status is always stored as one 32-bit word at memory location 64.

State machine:
- `S_IDLE`: on select, goes to `S_DECIDE`.
- `S_DECIDE`: goes to `S_RELEASE` (immediate code), `S_GET_CAW`, `S_DEV_CMD` or `S_PUT_CSW`.
- `S_GET_CAW`: on acknowledge, goes to `S_PUT_CSW` if the word is bad, otherwise to `S_GET_CCW`.
- `S_GET_CCW`: on acknowledge, goes to `S_DEV_CMD`.
- `S_DEV_CMD`: on done, goes to `S_RELEASE` (zero status), `S_DEV_CLR` (start with nonzero status) or `S_PUT_CSW` (test with nonzero status, or any halt).
- `S_DEV_CLR`: on done, goes to `S_PUT_CSW`.
- `S_PUT_CSW`: on acknowledge, goes to `S_RELEASE`.
- `S_RELEASE`: goes to `S_IDLE` after one cycle.

Top module: `iocc_ctrl`

## Requirements
- R1: After reset, the outputs are as follows.
  - `release_o`, `mem_req_o`, `dev_req_o` and `cc_o` are 0.
  - No interrupt is pending.
- R2: Operation codes are 0 start, 1 test, 2 halt and 3 test-channel. A start to a busy subchannel (`sc_busy_i`) releases with code 10. A start to an unavailable one (`sc_unavail_i`, checked after busy) releases with code 11. Neither case makes any memory or device request.
- R3: A start whose unit address fails odd parity stores status with channel byte 0x02 and returns 01. Otherwise the block reads address 72. Key = bits 31:28, command address = bits 23:0, and bits 27:24 must be zero. If bits 27:24 are nonzero or address bits 2:0 are nonzero, the block stores status with channel byte 0x01 and returns 01. The stored word is {unit address, 8'h00, device status, channel status}.
- R4: On a good address word, the next read is at the command address. The command code is read-data bits 31:24. `key_o` shows the key and `chain_addr_o` shows the command address plus 8.
- R5: The start command goes to the device. Zero status gives code 00. Nonzero status causes a second device request with code 0x00, then a store of {unit, 0, status, 0}, then code 01.
- R6: A test whose unit address equals the pending entry's address writes {pending address, 0, pending status} to 64, returns 01 and clears the entry.
- R7: A test with no match returns 10 if busy and 11 if unavailable. Otherwise it sends device code 0x00; zero status gives 00, and nonzero status stores {unit, 0, status, 0} and gives 01.
- R8: Test-channel ignores the unit address. It returns 11 when `tc_oper_i` is low; otherwise 01 if an interrupt is pending, otherwise 10 if `tc_all_burst_i` is high, otherwise 00. It makes no requests.
- R9: A halt whose address matches the pending entry returns 00 with no requests and keeps the entry. Otherwise it returns 11 if unavailable. Otherwise it sends device code 0xFF, stores {unit, 0, 0, 0} whatever the device returns, and returns 01.
- R10: `release_o` lasts exactly one cycle, `cc_o` is 00 outside it, and a select strobe arriving while an instruction is in progress is ignored.
- R11: A memory or device request holds its address, direction and command stable until acknowledged. The memory and device requests are never active together, and every memory write goes to address 64.
- R12: `int_post_i` loads the pending entry. A post in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Instruction select strobe |
| op_i | input | 2 | Operation code |
| ua_i | input | 8 | Unit address |
| ua_par_i | input | 1 | Odd parity bit over the unit address |
| sc_busy_i | input | 1 | Addressed subchannel busy |
| sc_unavail_i | input | 1 | Addressed subchannel unavailable |
| tc_oper_i | input | 1 | Channel operational |
| tc_all_burst_i | input | 1 | All interfaces in burst mode |
| int_post_i | input | 1 | Post a pending end interrupt |
| int_addr_i | input | 8 | Unit address of the posted interrupt |
| int_stat_i | input | 16 | Status of the posted interrupt {device, channel} |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 24 | Memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| dev_req_o | output | 1 | Device sequence request |
| dev_cmd_o | output | 8 | Command code for the device |
| dev_addr_o | output | 8 | Device unit address |
| dev_done_i | input | 1 | Device sequence finished |
| dev_status_i | input | 8 | Device status, valid with done |
| key_o | output | 4 | Protection key from the address word |
| chain_addr_o | output | 24 | Command address plus 8 |
| release_o | output | 1 | One-cycle release pulse |
| cc_o | output | 2 | Condition code, valid with release |

## Verification
The checker watches several rules on every cycle:
- the single-cycle release and the quiet condition code outside it;
- held memory and device requests;
- mutual exclusion of the two request ports;
- the fixed status-write address;
- 8-byte alignment of the chaining address.

The instruction-level outcomes can only be shown by the bench's scenarios. These are the condition code per operation and subchannel state, the read and write sequence, the stored status words, pending-entry matching and clearing, and the ignored mid-instruction select strobe.

// File: rtl/iocc_pkg.sv
package iocc_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_TEST  = 2'd1,
        OP_HALT  = 2'd2,
        OP_TCHAN = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECIDE,
        S_GET_CAW,
        S_GET_CCW,
        S_DEV_CMD,
        S_DEV_CLR,
        S_PUT_CSW,
        S_RELEASE
    } state_e;

    typedef enum logic [1:0] {
        ACT_RELEASE,
        ACT_GET_CAW,
        ACT_DEV,
        ACT_PUT
    } act_e;

    localparam logic [1:0] CC_OK     = 2'b00;
    localparam logic [1:0] CC_STORED = 2'b01;
    localparam logic [1:0] CC_BUSY   = 2'b10;
    localparam logic [1:0] CC_NOTOP  = 2'b11;

endpackage

// File: rtl/iocc_pend.sv
module iocc_pend #(
    parameter int UA_W = 8,
    parameter int SW_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post_i,
    input  logic [UA_W-1:0] post_addr_i,
    input  logic [SW_W-1:0] post_stat_i,
    input  logic            clear_i,
    output logic            valid_o,
    output logic [UA_W-1:0] addr_o,
    output logic [SW_W-1:0] stat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            stat_o  <= '0;
        end else if (post_i) begin
            valid_o <= 1'b1;
            addr_o  <= post_addr_i;
            stat_o  <= post_stat_i;
        end else if (clear_i) begin
            valid_o <= 1'b0;
        end
    end

endmodule

// File: rtl/iocc_decide.sv
module iocc_decide
    import iocc_pkg::*;
#(
    parameter int              UA_W     = 8,
    parameter int              ST_W     = 8,
    parameter logic [ST_W-1:0] TEST_CMD = 8'h00,
    parameter logic [ST_W-1:0] HALT_CMD = 8'hFF,
    parameter logic [ST_W-1:0] CH_UA    = 8'h02
) (
    input  op_e             op_i,
    input  logic [UA_W-1:0] ua_i,
    input  logic            par_i,
    input  logic            busy_i,
    input  logic            unav_i,
    input  logic            pend_v_i,
    input  logic [UA_W-1:0] pend_a_i,
    input  logic            oper_i,
    input  logic            burst_i,
    output act_e            act_o,
    output logic [1:0]      cc_o,
    output logic [ST_W-1:0] chan_o,
    output logic [ST_W-1:0] cmd_o,
    output logic            use_pend_o,
    output logic            clr_pend_o
);

    logic match;
    logic par_bad;

    assign match   = pend_v_i && (pend_a_i == ua_i);
    assign par_bad = ~(^{ua_i, par_i});

    always_comb begin
        act_o      = ACT_RELEASE;
        cc_o       = CC_OK;
        chan_o     = '0;
        cmd_o      = TEST_CMD;
        use_pend_o = 1'b0;
        clr_pend_o = 1'b0;
        unique case (op_i)
            OP_START: begin
                if (busy_i) begin
                    cc_o = CC_BUSY;
                end else if (unav_i) begin
                    cc_o = CC_NOTOP;
                end else if (par_bad) begin
                    act_o  = ACT_PUT;
                    cc_o   = CC_STORED;
                    chan_o = CH_UA;
                end else begin
                    act_o = ACT_GET_CAW;
                end
            end
            OP_TEST: begin
                if (match) begin
                    act_o      = ACT_PUT;
                    cc_o       = CC_STORED;
                    use_pend_o = 1'b1;
                    clr_pend_o = 1'b1;
                end else if (busy_i) begin
                    cc_o = CC_BUSY;
                end else if (unav_i) begin
                    cc_o = CC_NOTOP;
                end else begin
                    act_o = ACT_DEV;
                end
            end
            OP_HALT: begin
                if (match) begin
                    cc_o = CC_OK;
                end else if (unav_i) begin
                    cc_o = CC_NOTOP;
                end else begin
                    act_o = ACT_DEV;
                    cmd_o = HALT_CMD;
                end
            end
            OP_TCHAN: begin
                if (!oper_i)       cc_o = CC_NOTOP;
                else if (pend_v_i) cc_o = CC_STORED;
                else if (burst_i)  cc_o = CC_BUSY;
                else               cc_o = CC_OK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/iocc_ctrl.sv
module iocc_ctrl
    import iocc_pkg::*;
#(
    parameter int              UA_W     = 8,
    parameter int              ST_W     = 8,
    parameter int              MA_W     = 24,
    parameter int              DW       = 32,
    parameter int              KEY_W    = 4,
    parameter int              CAW_LOC  = 72,
    parameter int              CSW_LOC  = 64,
    parameter int              CCW_STEP = 8,
    parameter logic [ST_W-1:0] TEST_CMD = 8'h00,
    parameter logic [ST_W-1:0] HALT_CMD = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [1:0]        op_i,
    input  logic [UA_W-1:0]   ua_i,
    input  logic              ua_par_i,
    input  logic              sc_busy_i,
    input  logic              sc_unavail_i,
    input  logic              tc_oper_i,
    input  logic              tc_all_burst_i,
    input  logic              int_post_i,
    input  logic [UA_W-1:0]   int_addr_i,
    input  logic [2*ST_W-1:0] int_stat_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [MA_W-1:0]   mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              dev_req_o,
    output logic [ST_W-1:0]   dev_cmd_o,
    output logic [UA_W-1:0]   dev_addr_o,
    input  logic              dev_done_i,
    input  logic [ST_W-1:0]   dev_status_i,
    output logic [KEY_W-1:0]  key_o,
    output logic [MA_W-1:0]   chain_addr_o,
    output logic              release_o,
    output logic [1:0]        cc_o
);

    localparam int              PAD_W  = DW - UA_W - 2 * ST_W;
    localparam int              ZERO_W = DW - KEY_W - MA_W;
    localparam int              ALN_W  = $clog2(CCW_STEP);
    localparam logic [ST_W-1:0] CH_AW  = 8'h01;
    localparam logic [ST_W-1:0] CH_UA  = 8'h02;

    state_e            state_q, state_n;
    op_e               op_q;
    logic [UA_W-1:0]   ua_q;
    logic              par_q;
    logic [1:0]        cc_q;
    logic [KEY_W-1:0]  key_q;
    logic [MA_W-1:0]   cmd_addr_q;
    logic [MA_W-1:0]   chain_q;
    logic [ST_W-1:0]   dev_cmd_q;
    logic [DW-1:0]     csw_q;

    act_e              d_act;
    logic [1:0]        d_cc;
    logic [ST_W-1:0]   d_chan;
    logic [ST_W-1:0]   d_cmd;
    logic              d_use_pend;
    logic              d_clr_pend;

    logic              pend_v;
    logic [UA_W-1:0]   pend_a;
    logic [2*ST_W-1:0] pend_s;
    logic              pend_clr;
    logic              caw_bad;

    assign pend_clr = (state_q == S_DECIDE) && d_clr_pend;
    assign caw_bad  = (mem_rdata_i[DW-KEY_W-1 -: ZERO_W] != '0)
                   || (mem_rdata_i[ALN_W-1:0] != '0);

    iocc_pend #(.UA_W(UA_W), .SW_W(2 * ST_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .post_i      (int_post_i),
        .post_addr_i (int_addr_i),
        .post_stat_i (int_stat_i),
        .clear_i     (pend_clr),
        .valid_o     (pend_v),
        .addr_o      (pend_a),
        .stat_o      (pend_s)
    );

    iocc_decide #(
        .UA_W(UA_W), .ST_W(ST_W), .TEST_CMD(TEST_CMD),
        .HALT_CMD(HALT_CMD), .CH_UA(CH_UA)
    ) u_decide (
        .op_i       (op_q),
        .ua_i       (ua_q),
        .par_i      (par_q),
        .busy_i     (sc_busy_i),
        .unav_i     (sc_unavail_i),
        .pend_v_i   (pend_v),
        .pend_a_i   (pend_a),
        .oper_i     (tc_oper_i),
        .burst_i    (tc_all_burst_i),
        .act_o      (d_act),
        .cc_o       (d_cc),
        .chan_o     (d_chan),
        .cmd_o      (d_cmd),
        .use_pend_o (d_use_pend),
        .clr_pend_o (d_clr_pend)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:    if (sel_i) state_n = S_DECIDE;
            S_DECIDE: begin
                unique case (d_act)
                    ACT_GET_CAW: state_n = S_GET_CAW;
                    ACT_DEV:     state_n = S_DEV_CMD;
                    ACT_PUT:     state_n = S_PUT_CSW;
                    default:     state_n = S_RELEASE;
                endcase
            end
            S_GET_CAW: if (mem_ack_i) state_n = caw_bad ? S_PUT_CSW : S_GET_CCW;
            S_GET_CCW: if (mem_ack_i) state_n = S_DEV_CMD;
            S_DEV_CMD: begin
                if (dev_done_i) begin
                    if (op_q == OP_HALT)           state_n = S_PUT_CSW;
                    else if (dev_status_i == '0)   state_n = S_RELEASE;
                    else if (op_q == OP_START)     state_n = S_DEV_CLR;
                    else                           state_n = S_PUT_CSW;
                end
            end
            S_DEV_CLR: if (dev_done_i) state_n = S_PUT_CSW;
            S_PUT_CSW: if (mem_ack_i)  state_n = S_RELEASE;
            S_RELEASE: state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_START;
            ua_q       <= '0;
            par_q      <= 1'b0;
            cc_q       <= CC_OK;
            key_q      <= '0;
            cmd_addr_q <= '0;
            chain_q    <= '0;
            dev_cmd_q  <= TEST_CMD;
            csw_q      <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (sel_i) begin
                        op_q  <= op_e'(op_i);
                        ua_q  <= ua_i;
                        par_q <= ua_par_i;
                    end
                end
                S_DECIDE: begin
                    cc_q      <= d_cc;
                    dev_cmd_q <= d_cmd;
                    csw_q     <= d_use_pend ? {pend_a, {PAD_W{1'b0}}, pend_s}
                                            : {ua_q, {PAD_W{1'b0}}, {ST_W{1'b0}}, d_chan};
                end
                S_GET_CAW: begin
                    if (mem_ack_i) begin
                        key_q      <= mem_rdata_i[DW-1 -: KEY_W];
                        cmd_addr_q <= mem_rdata_i[MA_W-1:0];
                        cc_q       <= CC_STORED;
                        csw_q      <= {ua_q, {PAD_W{1'b0}}, {ST_W{1'b0}}, CH_AW};
                    end
                end
                S_GET_CCW: begin
                    if (mem_ack_i) begin
                        dev_cmd_q <= mem_rdata_i[DW-1 -: ST_W];
                        chain_q   <= cmd_addr_q + MA_W'(CCW_STEP);
                    end
                end
                S_DEV_CMD: begin
                    if (dev_done_i) begin
                        dev_cmd_q <= TEST_CMD;
                        cc_q      <= ((op_q == OP_HALT) || (dev_status_i != '0))
                                     ? CC_STORED : CC_OK;
                        csw_q     <= {ua_q, {PAD_W{1'b0}},
                                      (op_q == OP_HALT) ? {ST_W{1'b0}} : dev_status_i,
                                      {ST_W{1'b0}}};
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = MA_W'(CSW_LOC);
        mem_wdata_o = '0;
        dev_req_o   = 1'b0;
        release_o   = 1'b0;
        cc_o        = CC_OK;
        unique case (state_q)
            S_GET_CAW: begin
                mem_req_o  = 1'b1;
                mem_addr_o = MA_W'(CAW_LOC);
            end
            S_GET_CCW: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cmd_addr_q;
            end
            S_PUT_CSW: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = csw_q;
            end
            S_DEV_CMD, S_DEV_CLR: dev_req_o = 1'b1;
            S_RELEASE: begin
                release_o = 1'b1;
                cc_o      = cc_q;
            end
            default: ;
        endcase
    end

    assign dev_cmd_o    = dev_cmd_q;
    assign dev_addr_o   = ua_q;
    assign key_o        = key_q;
    assign chain_addr_o = chain_q;

endmodule

// File: rtl/iocc_ctrl_chk.sv
module iocc_ctrl_chk #(
    parameter int MA_W    = 24,
    parameter int ST_W    = 8,
    parameter int CSW_LOC = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            release_o,
    input logic [1:0]      cc_o,
    input logic            mem_req_o,
    input logic            mem_we_o,
    input logic [MA_W-1:0] mem_addr_o,
    input logic            mem_ack_i,
    input logic            dev_req_o,
    input logic [ST_W-1:0] dev_cmd_o,
    input logic            dev_done_i,
    input logic [MA_W-1:0] chain_addr_o
);

    p_release_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o);

    p_cc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !release_o |-> (cc_o == 2'b00));

    p_release_idle_ports_r10: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> (!mem_req_o && !dev_req_o));

    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    p_dev_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req_o && !dev_done_i) |=> (dev_req_o && $stable(dev_cmd_o)));

    p_req_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && dev_req_o));

    p_write_loc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |-> (mem_addr_o == MA_W'(CSW_LOC)));

    p_chain_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chain_addr_o[2:0] == 3'b000);

endmodule

bind iocc_ctrl iocc_ctrl_chk #(.MA_W(MA_W), .ST_W(ST_W), .CSW_LOC(CSW_LOC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .release_o    (release_o),
    .cc_o         (cc_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .dev_req_o    (dev_req_o),
    .dev_cmd_o    (dev_cmd_o),
    .dev_done_i   (dev_done_i),
    .chain_addr_o (chain_addr_o)
);

// File: tb/test_iocc_ctrl.sv
module test_iocc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [7:0]  ua_i = 8'h00;
    logic        ua_par_i = 1'b1;
    logic        sc_busy_i = 1'b0;
    logic        sc_unavail_i = 1'b0;
    logic        tc_oper_i = 1'b1;
    logic        tc_all_burst_i = 1'b0;
    logic        int_post_i = 1'b0;
    logic [7:0]  int_addr_i = 8'h00;
    logic [15:0] int_stat_i = 16'h0;
    logic        mem_req_o, mem_we_o;
    logic [23:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = 32'h0;
    logic        dev_req_o;
    logic [7:0]  dev_cmd_o, dev_addr_o;
    logic        dev_done_i = 1'b0;
    logic [7:0]  dev_status_i = 8'h00;
    logic [3:0]  key_o;
    logic [23:0] chain_addr_o;
    logic        release_o;
    logic [1:0]  cc_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    bit          pm_v = 1'b0;
    logic [7:0]  pm_a = 8'h00;
    logic [15:0] pm_s = 16'h0;

    always #10 clk = ~clk;

    iocc_ctrl i_iocc_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .op_i(op_i), .ua_i(ua_i),
        .ua_par_i(ua_par_i), .sc_busy_i(sc_busy_i), .sc_unavail_i(sc_unavail_i),
        .tc_oper_i(tc_oper_i), .tc_all_burst_i(tc_all_burst_i),
        .int_post_i(int_post_i), .int_addr_i(int_addr_i), .int_stat_i(int_stat_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .dev_req_o(dev_req_o), .dev_cmd_o(dev_cmd_o), .dev_addr_o(dev_addr_o),
        .dev_done_i(dev_done_i), .dev_status_i(dev_status_i), .key_o(key_o),
        .chain_addr_o(chain_addr_o), .release_o(release_o), .cc_o(cc_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic post_int(input logic [7:0] a, input logic [15:0] s);
        int_post_i = 1'b1;
        int_addr_i = a;
        int_stat_i = s;
        @(negedge clk);
        int_post_i = 1'b0;
        pm_v = 1'b1;
        pm_a = a;
        pm_s = s;
    endtask

    task automatic run_insn(input logic [1:0] op, input logic [7:0] ua, input bit par_ok,
                            input bit busy, input bit unav, input bit oper, input bit burst,
                            input logic [31:0] caw, input logic [31:0] ccw,
                            input logic [7:0] dst, input bit noise);
        logic [1:0]  e_cc = 2'b00;
        bit          e_wr = 1'b0;
        logic [31:0] e_wd = 32'h0;
        int          e_nrd = 0;
        int          e_ndev = 0;
        logic [7:0]  e_dev0 = 8'h00;
        bit          match;
        int          nrd = 0, nwr = 0, ndev = 0;
        logic [23:0] rd0 = '0, rd1 = '0;
        logic [31:0] wd = '0;
        logic [7:0]  dv0 = '0, dv1 = '0;
        logic [1:0]  got_cc = 2'b00;
        bit          seen = 1'b0;
        int          mw = 0, ml = 0, dw = 0, dl = 0;
        string       tg;

        match = pm_v && (pm_a == ua);
        case (op)
            2'd0: begin
                tg = "R2/R3/R4/R5 start";
                if (busy) e_cc = 2'b10;
                else if (unav) e_cc = 2'b11;
                else if (!par_ok) begin e_cc = 2'b01; e_wr = 1; e_wd = {ua, 8'h00, 8'h00, 8'h02}; end
                else if (caw[27:24] != 0 || caw[2:0] != 0) begin
                    e_nrd = 1; e_cc = 2'b01; e_wr = 1; e_wd = {ua, 8'h00, 8'h00, 8'h01};
                end else begin
                    e_nrd = 2; e_ndev = 1; e_dev0 = ccw[31:24];
                    if (dst == 0) e_cc = 2'b00;
                    else begin e_ndev = 2; e_cc = 2'b01; e_wr = 1; e_wd = {ua, 8'h00, dst, 8'h00}; end
                end
            end
            2'd1: begin
                tg = "R6/R7 test";
                if (match) begin e_cc = 2'b01; e_wr = 1; e_wd = {pm_a, 8'h00, pm_s}; end
                else if (busy) e_cc = 2'b10;
                else if (unav) e_cc = 2'b11;
                else begin
                    e_ndev = 1; e_dev0 = 8'h00;
                    if (dst == 0) e_cc = 2'b00;
                    else begin e_cc = 2'b01; e_wr = 1; e_wd = {ua, 8'h00, dst, 8'h00}; end
                end
            end
            2'd2: begin
                tg = "R9 halt";
                if (match) e_cc = 2'b00;
                else if (unav) e_cc = 2'b11;
                else begin e_ndev = 1; e_dev0 = 8'hFF; e_cc = 2'b01; e_wr = 1; e_wd = {ua, 24'h0}; end
            end
            default: begin
                tg = "R8 test-channel";
                if (!oper) e_cc = 2'b11;
                else if (pm_v) e_cc = 2'b01;
                else if (burst) e_cc = 2'b10;
                else e_cc = 2'b00;
            end
        endcase

        sc_busy_i = busy;
        sc_unavail_i = unav;
        tc_oper_i = oper;
        tc_all_burst_i = burst;
        op_i = op;
        ua_i = ua;
        ua_par_i = par_ok ? ~^ua : ^ua;
        sel_i = 1'b1;
        @(negedge clk);
        ml = $urandom % 3;
        dl = $urandom % 3;
        for (int c = 0; c < 300; c++) begin
            sel_i = noise && (c == 0);
            if (noise && c == 0) begin op_i = 2'd3; ua_i = ~ua; end
            mem_ack_i = 1'b0;
            dev_done_i = 1'b0;
            if (release_o) begin got_cc = cc_o; seen = 1'b1; break; end
            if (mem_req_o) begin
                if (mw >= ml) begin
                    mem_ack_i = 1'b1;
                    mem_rdata_i = (mem_addr_o == 24'd72) ? caw : ccw;
                    if (mem_we_o) begin nwr++; wd = mem_wdata_o; end
                    else begin
                        if (nrd == 0) rd0 = mem_addr_o; else rd1 = mem_addr_o;
                        nrd++;
                    end
                    mw = 0; ml = $urandom % 3;
                end else mw++;
            end
            if (dev_req_o) begin
                if (dw >= dl) begin
                    dev_done_i = 1'b1;
                    dev_status_i = (ndev == 0) ? dst : 8'h00;
                    if (ndev == 0) dv0 = dev_cmd_o; else dv1 = dev_cmd_o;
                    ndev++;
                    dw = 0; dl = $urandom % 3;
                end else dw++;
            end
            @(negedge clk);
        end
        mem_ack_i = 1'b0;
        dev_done_i = 1'b0;
        sel_i = 1'b0;
        check(seen, {tg, " release seen"}, 32'(seen), 32'd1);
        @(negedge clk);
        check(!release_o, "R10 release one cycle", 32'(release_o), 32'd0);
        check(got_cc == e_cc, {tg, " cc"}, 32'(got_cc), 32'(e_cc));
        check(nwr == int'(e_wr), {tg, " R11 store count"}, 32'(nwr), 32'(e_wr));
        if (e_wr && nwr == 1) check(wd == e_wd, {tg, " stored word"}, wd, e_wd);
        check(nrd == e_nrd, {tg, " read count"}, 32'(nrd), 32'(e_nrd));
        if (e_nrd >= 1 && nrd >= 1) check(rd0 == 24'd72, "R3 address word location", 32'(rd0), 32'd72);
        if (e_nrd == 2 && nrd == 2) begin
            check(rd1 == caw[23:0], "R4 command word address", 32'(rd1), 32'(caw[23:0]));
            check(key_o == caw[31:28], "R4 key", 32'(key_o), 32'(caw[31:28]));
            check(chain_addr_o == caw[23:0] + 24'd8, "R4 chain address", 32'(chain_addr_o),
                  32'(caw[23:0] + 24'd8));
        end
        check(ndev == e_ndev, {tg, " device request count"}, 32'(ndev), 32'(e_ndev));
        if (e_ndev >= 1 && ndev >= 1) check(dv0 == e_dev0, {tg, " device command"}, 32'(dv0), 32'(e_dev0));
        if (e_ndev == 2 && ndev == 2) check(dv1 == 8'h00, "R5 clearing test command", 32'(dv1), 32'h0);
        if (op == 2'd1 && match) pm_v = 1'b0;
    endtask

    initial begin
        logic [31:0] good_caw;
        repeat (3) @(negedge clk);
        check(!release_o && !mem_req_o && !dev_req_o && cc_o == 2'b00, "R1 reset outputs",
              {release_o, mem_req_o, dev_req_o, cc_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!release_o && !mem_req_o && !dev_req_o, "R1 idle after reset",
              {release_o, mem_req_o, dev_req_o}, 32'h0);
        void'($urandom(32'd1234));
        good_caw = 32'h5000_1238;
        // R1: no pending interrupt after reset
        run_insn(2'd3, 8'h11, 1, 0, 0, 1, 0, 0, 0, 0, 0);
        // R2 busy and unavailable start
        run_insn(2'd0, 8'h21, 1, 1, 0, 1, 0, good_caw, 32'h0200_0000, 0, 0);
        run_insn(2'd0, 8'h21, 1, 0, 1, 1, 0, good_caw, 32'h0200_0000, 0, 0);
        // R3 parity error, misaligned and nonzero reserved bits
        run_insn(2'd0, 8'h33, 0, 0, 0, 1, 0, good_caw, 32'h0200_0000, 0, 0);
        run_insn(2'd0, 8'h33, 1, 0, 0, 1, 0, 32'h5000_1234, 32'h0200_0000, 0, 0);
        run_insn(2'd0, 8'h33, 1, 0, 0, 1, 0, 32'h5300_1238, 32'h0200_0000, 0, 0);
        // R4/R5 good start, zero and nonzero status
        run_insn(2'd0, 8'h44, 1, 0, 0, 1, 0, good_caw, 32'h0200_0000, 8'h00, 0);
        run_insn(2'd0, 8'h45, 1, 0, 0, 1, 0, 32'hA0FF_FFF8, 32'h0900_0000, 8'h0C, 0);
        // R10 select strobe during an instruction
        run_insn(2'd0, 8'h46, 1, 0, 0, 1, 0, good_caw, 32'h0100_0000, 8'h00, 1);
        // R12 post, R8 pending, R9 halt match, R6 test match and clear
        post_int(8'h5A, 16'hBEEF);
        run_insn(2'd3, 8'h00, 1, 0, 0, 1, 1, 0, 0, 0, 0);
        run_insn(2'd2, 8'h5A, 1, 0, 0, 1, 0, 0, 0, 8'h40, 0);
        run_insn(2'd1, 8'h5A, 1, 1, 0, 1, 0, 0, 0, 0, 0);
        run_insn(2'd3, 8'h5A, 1, 0, 0, 1, 1, 0, 0, 0, 0);
        // R8 not operational, R7 and R9 non-matching paths
        run_insn(2'd3, 8'h5A, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        run_insn(2'd1, 8'h60, 1, 0, 0, 1, 0, 0, 0, 8'h00, 0);
        run_insn(2'd1, 8'h61, 1, 0, 0, 1, 0, 0, 0, 8'h0E, 0);
        run_insn(2'd2, 8'h62, 1, 0, 0, 1, 0, 0, 0, 8'h80, 0);
        run_insn(2'd2, 8'h63, 1, 0, 1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 300; i++) begin
            logic [7:0]  ua;
            logic [31:0] caw;
            if ($urandom % 8 == 0) post_int(8'($urandom), 16'($urandom));
            ua = ($urandom % 3 == 0) ? pm_a : 8'($urandom);
            caw = $urandom;
            if ($urandom % 4 != 0) caw = {caw[31:28], 4'h0, caw[23:3], 3'b000};
            run_insn(2'($urandom), ua, ($urandom % 8) != 0, ($urandom % 5) == 0,
                     ($urandom % 5) == 0, ($urandom % 6) != 0, ($urandom % 2) == 0,
                     caw, $urandom, ($urandom % 2 == 0) ? 8'h00 : 8'($urandom),
                     ($urandom % 6) == 0);
        end
        finish_run();
    end

endmodule